// File: doc/BRIEF.md
# Block-transfer serial channel with buffer RAM

This block moves a block of 1 to 32 bytes between a local 32x8 buffer RAM and a clock-synchronous serial line, with no help from the processor per byte. Software fills the buffer through a simple RAM port, programs a length code and pulses start. The channel then shifts every byte out on SO while it shifts the peer's byte in from SI. Each received byte replaces, in the buffer, the byte that was just sent.

The serial clock is either generated inside the block (master) or taken from the SCK pin through a two-stage synchronizer (slave). An optional chip-select mode lets an active-low select input gate the transfer. While the select is high, the SCK and SO drivers are released and the transfer freezes where it stands. When the select returns low, the transfer continues from that bit. Completion raises a sticky interrupt flag.

Top module: `spi_auto_xfer`

## Requirements
- R1: A length code L (0 to 31) sampled on an accepted start moves exactly L+1 bytes. busy_o then falls, no sooner than the final bit's rising SCK edge.
- R2: Bytes are sent MSB first, from buffer addresses 0, 1, 2 and upward. The byte received during byte slot k is written to address k, and addresses at k >= L+1 are left unchanged.
- R3: SI is sampled on a rising SCK edge, and SO changes only after a falling SCK edge. The first falling edge of each byte presents bit 7.
- R4: Out of reset, and whenever busy_o is low, sck_o and so_o are both 1 and irq_o is 0 after reset.
- R5: With master_i=1, SCK is generated internally: each low phase and each high phase lasts HALF_DIV clock cycles, and sck_oe_o is 1 while chip-select mode is off.
- R6: With master_i=0, sck_oe_o is 0 and the transfer is clocked by edges of sck_i, seen through a two-flop synchronizer.
- R7: With cs_mode_i=1, cs_ni high makes sck_oe_o and so_oe_o 0 within 3 cycles. cs_ni low enables so_oe_o, and enables sck_oe_o as well when master_i=1. With cs_mode_i=0, cs_ni has no effect.
- R8: If the select rises in the middle of a transfer, the bit position, the buffer address and the generated SCK level are held. SCK edges arriving during the pause are ignored. The transfer resumes when the select falls.
- R9: A start pulse while busy_o is 1 is ignored, including its length code.
- R10: irq_o is set in the cycle in which busy_o falls at the end of a block, and is cleared by the next accepted start.
- R11: Processor writes to the buffer are ignored while busy_o is 1. Reads of ram_rdata_o are combinational at ram_addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| len_i | input | 5 | Length code, bytes minus one |
| master_i | input | 1 | 1: generate SCK, 0: follow sck_i |
| cs_mode_i | input | 1 | 1: cs_ni gates the transfer |
| busy_o | output | 1 | Block transfer in progress |
| irq_o | output | 1 | Sticky completion flag |
| ram_we_i | input | 1 | Buffer write strobe |
| ram_addr_i | input | 5 | Buffer address |
| ram_wdata_i | input | 8 | Buffer write data |
| ram_rdata_o | output | 8 | Buffer read data |
| sck_i | input | 1 | Serial clock from pin (slave) |
| sck_o | output | 1 | Generated serial clock |
| sck_oe_o | output | 1 | SCK driver enable |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | SO driver enable |
| cs_ni | input | 1 | Chip select, active low |

## Verification
Some rules are checked by the assertions on every cycle. SO moves only after a falling-edge event, and both lines sit high whenever no transfer runs. A paused transfer holds its bit counter, its address and the generated clock level. The byte counter is never zero while busy, and the completion flag rises only as busy falls. Other behaviours show only through the bench's scenarios: the MSB-first ordering, the write-back of received bytes to the right addresses, the exact byte count at lengths 1 and 32, the measured SCK phase lengths, the release of the drivers by the chip select, and the ignoring of a repeated start or of buffer writes during a transfer.

// File: rtl/spi_auto_pkg.sv
`timescale 1ns/1ps
package spi_auto_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BIT_W  = $clog2(BYTE_W);
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/spi_sync2.sv
`timescale 1ns/1ps
module spi_sync2 #(
  parameter int unsigned      W       = 1,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/spi_buf_ram.sv
`timescale 1ns/1ps
module spi_buf_ram
  import spi_auto_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_addr_i,
  input  byte_t         a_wdata_i,
  output byte_t         a_rdata_o,
  input  logic          b_we_i,
  input  logic [AW-1:0] b_addr_i,
  input  byte_t         b_wdata_i,
  output byte_t         b_rdata_o
);
  byte_t mem [DEPTH];

  // engine port wins; top already blocks port a while busy
  always_ff @(posedge clk_i) begin
    if (b_we_i)      mem[b_addr_i] <= b_wdata_i;
    else if (a_we_i) mem[a_addr_i] <= a_wdata_i;
  end

  assign a_rdata_o = mem[a_addr_i];
  assign b_rdata_o = mem[b_addr_i];
endmodule

// File: rtl/spi_edge_src.sv
`timescale 1ns/1ps
module spi_edge_src #(
  parameter int unsigned HALF_DIV = 4,
  localparam int unsigned CW      = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_i,
  input  logic run_i,
  input  logic clear_i,
  input  logic sck_sync_i,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);
  logic [CW-1:0] cnt_q;
  logic          sck_q, prev_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sck_q  <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      prev_q <= sck_sync_i;
      if (clear_i) begin
        cnt_q <= '0;
        sck_q <= 1'b1;
      end else if (master_i && run_i) begin
        if (wrap) begin
          cnt_q <= '0;
          sck_q <= ~sck_q;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign sck_o  = sck_q;
  assign rise_o = run_i & (master_i ? (wrap & ~sck_q) : (~prev_q & sck_sync_i));
  assign fall_o = run_i & (master_i ? (wrap &  sck_q) : ( prev_q & ~sck_sync_i));

  p_edge_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));

  p_clk_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clear_i) |=> $stable(sck_q));
endmodule

// File: rtl/spi_auto_xfer.sv
`timescale 1ns/1ps
module spi_auto_xfer
  import spi_auto_pkg::*;
#(
  parameter int unsigned DEPTH    = 32,
  parameter int unsigned HALF_DIV = 4,
  localparam int unsigned AW      = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] len_i,
  input  logic          master_i,
  input  logic          cs_mode_i,
  output logic          busy_o,
  output logic          irq_o,
  input  logic          ram_we_i,
  input  logic [AW-1:0] ram_addr_i,
  input  logic [7:0]    ram_wdata_i,
  output logic [7:0]    ram_rdata_o,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe_o,
  input  logic          si_i,
  output logic          so_o,
  output logic          so_oe_o,
  input  logic          cs_ni
);
  logic              busy_q, irq_q, so_q;
  logic [AW-1:0]     addr_q;
  logic [AW:0]       left_q;
  logic [BIT_W-1:0]  bit_q;
  byte_t             tx_q, rx_q, rd_b, rx_full;
  logic [2:0]        pin_s;
  logic              cs_s, sck_s, si_s, cs_ok, run, accept, rise_ev, fall_ev, last_bit, wr_b;

  spi_sync2 #(.W(3), .RST_VAL(3'b110)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .d_i   ({cs_ni, sck_i, si_i}),
    .q_o   (pin_s)
  );
  assign {cs_s, sck_s} = pin_s[2:1];
  assign si_s = master_i ? si_i : pin_s[0];

  assign accept   = start_i & ~busy_q;
  assign cs_ok    = ~cs_mode_i | ~cs_s;
  assign run      = busy_q & cs_ok;
  assign last_bit = (bit_q == BIT_W'(BYTE_W - 1));
  assign wr_b     = rise_ev & last_bit;
  assign rx_full  = {rx_q[BYTE_W-2:0], si_s};

  spi_edge_src #(.HALF_DIV(HALF_DIV)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .master_i  (master_i),
    .run_i     (run),
    .clear_i   (accept),
    .sck_sync_i(sck_s),
    .sck_o     (sck_o),
    .rise_o    (rise_ev),
    .fall_o    (fall_ev)
  );

  spi_buf_ram #(.DEPTH(DEPTH)) u_ram (
    .clk_i    (clk_i),
    .a_we_i   (ram_we_i & ~busy_q),
    .a_addr_i (ram_addr_i),
    .a_wdata_i(ram_wdata_i),
    .a_rdata_o(ram_rdata_o),
    .b_we_i   (wr_b),
    .b_addr_i (addr_q),
    .b_wdata_i(rx_full),
    .b_rdata_o(rd_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
      so_q   <= 1'b1;
      addr_q <= '0;
      left_q <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      irq_q  <= 1'b0;
      so_q   <= 1'b1;
      addr_q <= '0;
      left_q <= {1'b0, len_i} + (AW+1)'(1);
      bit_q  <= '0;
    end else begin
      if (fall_ev) begin
        if (bit_q == '0) begin
          so_q <= rd_b[BYTE_W-1];
          tx_q <= {rd_b[BYTE_W-2:0], 1'b0};
        end else begin
          so_q <= tx_q[BYTE_W-1];
          tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
      if (rise_ev) begin
        rx_q  <= rx_full;
        bit_q <= bit_q + BIT_W'(1);
        if (last_bit) begin
          addr_q <= addr_q + AW'(1);
          left_q <= left_q - (AW+1)'(1);
          if (left_q == (AW+1)'(1)) begin
            busy_q <= 1'b0;
            irq_q  <= 1'b1;
            so_q   <= 1'b1;
          end
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign irq_o    = irq_q;
  assign so_o     = so_q;
  assign so_oe_o  = cs_ok;
  assign sck_oe_o = master_i & cs_ok;

  p_so_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !$stable(so_q)) |-> $past(fall_ev));

  p_idle_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (sck_o && so_o));

  p_pause_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !cs_ok) |=> ($stable(bit_q) && $stable(addr_q)));

  p_cnt_live_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (left_q != '0));

  p_irq_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $fell(busy_q));
endmodule

// File: tb/tb_spi_auto_xfer.sv
`timescale 1ns/1ps
module tb_spi_auto_xfer;
  localparam int HALF = 4;
  localparam int TCLK = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, master_i = 1, cs_mode_i = 0, ram_we_i = 0;
  logic [4:0] len_i = '0, ram_addr_i = '0;
  logic [7:0] ram_wdata_i = '0, ram_rdata_o;
  logic busy_o, irq_o, sck_o, sck_oe_o, so_o, so_oe_o;
  logic sck_i = 1'b1, si_i = 1'b0, cs_ni = 1'b1;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] pre [32];
  logic [7:0] peer [32];
  logic [7:0] got [32];
  realtime t0, t1, t2;

  always #(TCLK/2) clk = ~clk;

  spi_auto_xfer #(.DEPTH(32), .HALF_DIV(HALF)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .len_i(len_i),
    .master_i(master_i), .cs_mode_i(cs_mode_i), .busy_o(busy_o), .irq_o(irq_o),
    .ram_we_i(ram_we_i), .ram_addr_i(ram_addr_i), .ram_wdata_i(ram_wdata_i),
    .ram_rdata_o(ram_rdata_o), .sck_i(sck_i), .sck_o(sck_o), .sck_oe_o(sck_oe_o),
    .si_i(si_i), .so_o(so_o), .so_oe_o(so_oe_o), .cs_ni(cs_ni)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    ram_we_i = 1; ram_addr_i = 5'(a); ram_wdata_i = d;
    @(negedge clk);
    ram_we_i = 0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    ram_addr_i = 5'(a);
    #1 d = ram_rdata_o;
  endtask

  task automatic go(input int len_code);
    @(negedge clk);
    len_i = 5'(len_code); start_i = 1;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic prep(input int n);
    for (int i = 0; i < 32; i++) begin
      pre[i]  = 8'($urandom);
      peer[i] = 8'($urandom);
      got[i]  = 8'h00;
      wr(i, pre[i]);
    end
  endtask

  task automatic check_result(input int n);
    logic [7:0] d;
    for (int i = 0; i < n; i++)
      chk(got[i] == pre[i], "R2 tx byte order", got[i], pre[i]);
    for (int i = 0; i < 32; i++) begin
      rd(i, d);
      if (i < n) chk(d == peer[i], "R2 rx write-back", d, peer[i]);
      else       chk(d == pre[i], "R2/R11 untouched buffer", d, pre[i]);
    end
  endtask

  task automatic peer_master(input int n);
    for (int b = 0; b < n; b++)
      for (int k = 0; k < 8; k++) begin
        @(negedge sck_o);
        if (b == 0 && k == 1) t2 = $realtime;
        if (b == 0 && k == 0) t0 = $realtime;
        #1;
        got[b][7-k] = so_o;
        si_i = peer[b][7-k];
        if (b == 0 && k == 0) begin
          @(posedge sck_o);
          t1 = $realtime;
        end
      end
  endtask

  task automatic master_run(input int n, input bit mid_start, input bit cpu_wr, input bit pause);
    logic s;
    master_i = 1;
    prep(n);
    fork
      peer_master(n);
      begin
        go(n - 1);
        chk(irq_o == 0, "R10 irq cleared by start", irq_o, 0);
        chk(busy_o == 1, "R1 busy after start", busy_o, 1);
        if (mid_start) begin
          repeat (20) @(negedge clk);
          go(31 - (n - 1));
        end
        if (cpu_wr) wr(31, ~pre[31]);
        if (pause) begin
          repeat (30) @(negedge clk);
          cs_ni = 1;
          repeat (4) @(negedge clk);
          chk(sck_oe_o == 0, "R7 sck float on cs high", sck_oe_o, 0);
          chk(so_oe_o == 0, "R7 so float on cs high", so_oe_o, 0);
          chk(busy_o == 1, "R8 busy held in pause", busy_o, 1);
          s = sck_o;
          repeat (20) @(negedge clk);
          chk(sck_o == s, "R8 sck frozen in pause", sck_o, s);
          cs_ni = 0;
          repeat (4) @(negedge clk);
          chk(sck_oe_o == 1, "R7 sck driven on cs low", sck_oe_o, 1);
        end
      end
    join
    chk(busy_o == 1, "R1 busy until last rising edge", busy_o, 1);
    repeat (2 * HALF + 4) @(negedge clk);
    chk(busy_o == 0, "R1 done after L+1 bytes", busy_o, 0);
    chk(irq_o == 1, "R10 irq at end", irq_o, 1);
    chk(sck_o == 1 && so_o == 1, "R4 idle high", {sck_o, so_o}, 3);
    chk(int'(t1 - t0) == HALF * TCLK, "R5 low phase", int'(t1 - t0), HALF * TCLK);
    chk(int'(t2 - t1) == HALF * TCLK, "R5 high phase", int'(t2 - t1), HALF * TCLK);
    check_result(n);
  endtask

  task automatic slave_run(input int n, input bit pause);
    master_i = 0;
    prep(n);
    go(n - 1);
    chk(sck_oe_o == 0, "R6 slave sck not driven", sck_oe_o, 0);
    for (int b = 0; b < n; b++)
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        sck_i = 0;
        repeat (4) @(negedge clk);
        got[b][7-k] = so_o;
        si_i = peer[b][7-k];
        if (b == n - 1 && k == 7) chk(busy_o == 1, "R1 busy before last rise", busy_o, 1);
        sck_i = 1;
        repeat (4) @(negedge clk);
        if (pause && b == 0 && k == 3) begin
          cs_ni = 1;
          repeat (4) @(negedge clk);
          chk(so_oe_o == 0, "R7 so float in pause", so_oe_o, 0);
          sck_i = 0;
          repeat (4) @(negedge clk);
          sck_i = 1;
          repeat (4) @(negedge clk);
          chk(busy_o == 1, "R8 pause ignores sck edges", busy_o, 1);
          cs_ni = 0;
          repeat (4) @(negedge clk);
          chk(so_oe_o == 1, "R7 so driven on cs low", so_oe_o, 1);
        end
      end
    chk(busy_o == 0, "R1 slave done", busy_o, 0);
    chk(irq_o == 1, "R10 slave irq", irq_o, 1);
    check_result(n);
  endtask

  initial begin
    #(TCLK * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk(busy_o == 0, "R4 reset busy", busy_o, 0);
    chk(irq_o == 0, "R4 reset irq", irq_o, 0);
    chk(sck_o == 1 && so_o == 1, "R4 reset lines high", {sck_o, so_o}, 3);
    chk(sck_oe_o == 1 && so_oe_o == 1, "R5 master drives", {sck_oe_o, so_oe_o}, 3);
    cs_ni = 1;
    chk(so_oe_o == 1, "R7 cs ignored when mode off", so_oe_o, 1);

    master_run(1, 0, 0, 0);
    master_run(32, 0, 0, 0);
    master_run(5, 1, 1, 0);   // R9 restart ignored, R11 write ignored
    for (int r = 0; r < 3; r++) master_run(1 + int'($urandom % 32), 0, 0, 0);

    slave_run(3, 0);

    cs_mode_i = 1; cs_ni = 1;
    repeat (4) @(negedge clk);
    master_i = 1;
    #1;
    chk(sck_oe_o == 0 && so_oe_o == 0, "R7 idle float with cs high", {sck_oe_o, so_oe_o}, 0);
    cs_ni = 0;
    repeat (4) @(negedge clk);
    slave_run(2, 1);
    master_run(2, 0, 0, 1);

    summary();
  end
endmodule